// File: doc/BRIEF.md
# PLL Reference Switchover Supervisor

This block runs a PLL through the move from one reference clock to the other, and it keeps downstream logic safe while the loop settles. Its clock is a free-running system clock that is independent of both references. Its inputs are a status flag for each reference that reports a missing or bad clock, the PLL lock flag and a level switchover request. It drives the phase-detector enable, the PLL reset, a one-cycle switch strobe to the reference mux and a clock-enable for each PLL output. All asynchronous inputs pass through two-flop synchronizers before the sequencer sees them.

A switchover runs in a fixed order. The sequencer gates the outputs and freezes the VCO by disabling the phase detector. It waits until both references are reported healthy, fires the switch strobe, and holds the PLL in reset for at least a minimum time. It then re-enables the outputs only after lock has held for a set number of consecutive cycles. A bad-reference event that arrives without a request takes the same path without the strobe, so the PLL re-locks on the reference it already had. If lock does not come within a timeout, the sequencer parks in a fault state that only an explicit clear can leave.

States: IDLE (waiting for the first lock after reset), RUN (outputs enabled), FREEZE (phase detector off and outputs gated, waiting for healthy references), SWITCH (one-cycle strobe), RST_PULSE (PLL reset held), WAIT_LOCK (waiting for stable lock, watchdog running) and FAULT (lock timeout). Transitions:
- IDLE to RUN on stable lock.
- RUN to FREEZE on a bad flag or a request.
- FREEZE to SWITCH when both flags are clear and a request is present.
- FREEZE to RST_PULSE when both flags are clear and no request is present.
- SWITCH to RST_PULSE always.
- RST_PULSE to WAIT_LOCK after the pulse length.
- WAIT_LOCK to RUN on stable lock.
- WAIT_LOCK to FAULT on timeout.
- FAULT to IDLE on clear.

Top module: `pll_swo_supervisor`

## Requirements
- R1: While reset is held and right after it, the state is IDLE. In that state `pfd_en_o`=1, `pll_rst_o`=0, `swo_strobe_o`=0, `clk_en_o`=0, `sel_ref_o`=0 and `fault_o`=0.
- R2: `pfd_en_o` is 0 whenever either synchronized bad flag is 1, and also throughout FREEZE, SWITCH and RST_PULSE. Otherwise it is 1.
- R3: `clk_en_o` is all ones in RUN and all zeros in every other state. Its bits never differ from one another.
- R4: `swo_strobe_o` is raised only when the sequencer leaves FREEZE with both synchronized bad flags at 0 and the synchronized request at 1. A request made while either flag is 1 is held off with no strobe. A freeze caused by a bad flag alone ends without a strobe.
- R5: `swo_strobe_o` is high for exactly one system-clock cycle per switchover.
- R6: `sel_ref_o` inverts in the cycle after each strobe and changes at no other time except reset.
- R7: `pll_rst_o` is high for exactly ceil(RST_MIN_PS / CLK_PERIOD_PS) consecutive cycles after each switch or re-lock freeze. With a 5000 ps clock and 12000 ps minimum, that is 3 cycles.
- R8: The outputs are released only after the synchronized lock flag has been 1 for LOCK_STABLE consecutive cycles. Any low cycle restarts the count.
- R9: If stable lock is not reached within LOCK_TIMEOUT cycles of WAIT_LOCK, the state becomes FAULT and `fault_o` goes to 1.
- R10: FAULT is held until `fault_clr_i` is 1 at a clock edge, which returns the sequencer to IDLE. Lock alone does not clear it.
- R11: A change on a bad flag pin reaches `pfd_en_o` after exactly two system-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_bad_a_i | input | 1 | Reference A reported bad (asynchronous) |
| ref_bad_b_i | input | 1 | Reference B reported bad (asynchronous) |
| pll_locked_i | input | 1 | PLL lock flag (asynchronous) |
| swo_req_i | input | 1 | Switchover request level (asynchronous) |
| fault_clr_i | input | 1 | Synchronous clear of the fault state |
| pfd_en_o | output | 1 | Phase-detector enable |
| pll_rst_o | output | 1 | PLL reset |
| swo_strobe_o | output | 1 | One-cycle strobe that flips the reference selection |
| clk_en_o | output | N_OUT | Per-output clock enables |
| sel_ref_o | output | 1 | Reference currently selected (0 = A, 1 = B) |
| fault_o | output | 1 | Lock timeout fault |

## Verification
The bench goes after four corner cases. The first is a lock flag that drops just short of the stability count; a qualifier that only paused instead of restarting would release the outputs early. The second is a request that arrives while a reference is bad; a sequencer that ignored the flags would strobe the mux onto a dead clock. The third is a freeze caused by a bad flag alone; a design that strobed or flipped the selection there would change references with no request. The fourth covers the reset pulse length with a minimum that does not divide evenly into the clock period, and a lock timeout followed by lock returning while in FAULT. A truncating division would give a short reset pulse, and an automatic exit would leave the fault state with no clear.

// File: rtl/swo_pkg.sv
package swo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREEZE,
        ST_SWITCH,
        ST_RST_PULSE,
        ST_WAIT_LOCK,
        ST_RUN,
        ST_FAULT
    } swo_state_e;
endpackage

// File: rtl/swo_sync.sv
module swo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= 1'b0;
                q[i] <= 1'b0;
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/swo_lock_qual.sv
module swo_lock_qual #(
    parameter int STABLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic locked,
    output logic stable
);
    localparam int CW = $clog2(STABLE + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !locked) begin
            cnt <= '0;
        end else if (cnt != CW'(STABLE)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stable = (cnt == CW'(STABLE));
endmodule

// File: rtl/swo_span_cnt.sv
module swo_span_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pll_swo_supervisor.sv
module pll_swo_supervisor
    import swo_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int RST_MIN_PS    = 10000,
    parameter int LOCK_STABLE   = 16,
    parameter int LOCK_TIMEOUT  = 4096,
    parameter int N_OUT         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_bad_a_i,
    input  logic             ref_bad_b_i,
    input  logic             pll_locked_i,
    input  logic             swo_req_i,
    input  logic             fault_clr_i,
    output logic             pfd_en_o,
    output logic             pll_rst_o,
    output logic             swo_strobe_o,
    output logic [N_OUT-1:0] clk_en_o,
    output logic             sel_ref_o,
    output logic             fault_o
);
    localparam int RST_CYC = (RST_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RST_LIM = (RST_CYC < 1) ? 1 : RST_CYC;

    swo_state_e state, state_nx;
    logic [3:0] sync_q;
    logic bad_a_s, bad_b_s, locked_s, req_s, bad_any;
    logic lock_ok, rst_done, tmo_hit, qual_clr;
    logic en_all;

    swo_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({swo_req_i, pll_locked_i, ref_bad_b_i, ref_bad_a_i}),
        .q     (sync_q)
    );
    assign {req_s, locked_s, bad_b_s, bad_a_s} = sync_q;
    assign bad_any = bad_a_s | bad_b_s;

    assign qual_clr = (state == ST_FREEZE) || (state == ST_SWITCH) ||
                      (state == ST_RST_PULSE) || (state == ST_FAULT);

    swo_lock_qual #(.STABLE(LOCK_STABLE)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (qual_clr),
        .locked (locked_s),
        .stable (lock_ok)
    );

    swo_span_cnt #(.LIMIT(RST_LIM)) u_rst_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RST_PULSE),
        .done  (rst_done)
    );

    swo_span_cnt #(.LIMIT(LOCK_TIMEOUT)) u_tmo_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAIT_LOCK),
        .done  (tmo_hit)
    );

    // state register and selection tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel_ref_o <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_SWITCH) begin
                sel_ref_o <= ~sel_ref_o;
            end
        end
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (lock_ok) state_nx = ST_RUN;
            ST_RUN:       if (bad_any || req_s) state_nx = ST_FREEZE;
            ST_FREEZE:    if (!bad_any) state_nx = req_s ? ST_SWITCH : ST_RST_PULSE;
            ST_SWITCH:    state_nx = ST_RST_PULSE;
            ST_RST_PULSE: if (rst_done) state_nx = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (lock_ok)      state_nx = ST_RUN;
                else if (tmo_hit) state_nx = ST_FAULT;
            end
            ST_FAULT:     if (fault_clr_i) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        logic pfd_state;
        pfd_state    = 1'b1;
        pll_rst_o    = 1'b0;
        swo_strobe_o = 1'b0;
        en_all       = 1'b0;
        fault_o      = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_RUN:       en_all = 1'b1;
            ST_FREEZE:    pfd_state = 1'b0;
            ST_SWITCH:    begin pfd_state = 1'b0; swo_strobe_o = 1'b1; end
            ST_RST_PULSE: begin pfd_state = 1'b0; pll_rst_o = 1'b1; end
            ST_WAIT_LOCK: ;
            ST_FAULT:     fault_o = 1'b1;
            default:      ;
        endcase
        pfd_en_o = pfd_state & ~bad_any;
    end

    assign clk_en_o = {N_OUT{en_all}};
endmodule

// File: rtl/swo_checker.sv
module swo_checker #(
    parameter int RST_CYC = 2,
    parameter int N_OUT   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_clr_i,
    input logic             pfd_en_o,
    input logic             pll_rst_o,
    input logic             swo_strobe_o,
    input logic [N_OUT-1:0] clk_en_o,
    input logic             sel_ref_o,
    input logic             fault_o
);
    int unsigned rst_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rst_run <= 0;
        else if (pll_rst_o) rst_run <= rst_run + 1;
        else                rst_run <= 0;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        swo_strobe_o |=> !swo_strobe_o); // R5
    AST_STROBE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        swo_strobe_o |-> (!pfd_en_o && clk_en_o == '0)); // R2
    AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        swo_strobe_o |=> (sel_ref_o != $past(sel_ref_o))); // R6
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !swo_strobe_o |=> $stable(sel_ref_o)); // R6
    AST_RST_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        swo_strobe_o |=> pll_rst_o); // R7
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_o) |-> (rst_run == RST_CYC)); // R7
    AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> (clk_en_o == '0 && !pfd_en_o)); // R3
    AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(clk_en_o) == 0 || $countones(clk_en_o) == N_OUT)); // R3
    AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (clk_en_o == '0)); // R3
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_clr_i) |=> fault_o); // R10
endmodule

bind pll_swo_supervisor swo_checker #(
    .RST_CYC (RST_LIM),
    .N_OUT   (N_OUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_clr_i  (fault_clr_i),
    .pfd_en_o     (pfd_en_o),
    .pll_rst_o    (pll_rst_o),
    .swo_strobe_o (swo_strobe_o),
    .clk_en_o     (clk_en_o),
    .sel_ref_o    (sel_ref_o),
    .fault_o      (fault_o)
);

// File: tb/pll_swo_supervisor_tb.sv
module pll_swo_supervisor_tb;
    localparam int PER_PS = 5000;
    localparam int RMIN   = 12000;
    localparam int LS     = 16;
    localparam int TO     = 200;
    localparam int NO     = 4;
    localparam int RC     = 3;  // ceil(12000/5000)

    localparam int M_IDLE = 0, M_FREEZE = 1, M_SWITCH = 2, M_RSTP = 3,
                   M_WAIT = 4, M_RUN = 5, M_FAULT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bad_a = 1'b0, bad_b = 1'b0, locked = 1'b0, req = 1'b0, fclr = 1'b0;
    logic pfd_en, pll_rst, strobe, sel, fault;
    logic [NO-1:0] clk_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;

    always #2500ps clk = ~clk;

    pll_swo_supervisor #(
        .CLK_PERIOD_PS (PER_PS),
        .RST_MIN_PS    (RMIN),
        .LOCK_STABLE   (LS),
        .LOCK_TIMEOUT  (TO),
        .N_OUT         (NO)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_bad_a_i  (bad_a),
        .ref_bad_b_i  (bad_b),
        .pll_locked_i (locked),
        .swo_req_i    (req),
        .fault_clr_i  (fclr),
        .pfd_en_o     (pfd_en),
        .pll_rst_o    (pll_rst),
        .swo_strobe_o (strobe),
        .clk_en_o     (clk_en),
        .sel_ref_o    (sel),
        .fault_o      (fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_st, m_lcnt, m_rcnt, m_tcnt, m_nst;
    bit  m_sel, m_bad;
    bit  a_q[$], b_q[$], l_q[$], r_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_lcnt = 0; m_rcnt = 0; m_tcnt = 0; m_sel = 0;
            a_q = '{0, 0}; b_q = '{0, 0}; l_q = '{0, 0}; r_q = '{0, 0};
        end else begin
            m_bad = a_q[0] | b_q[0];
            m_nst = m_st;
            case (m_st)
                M_IDLE:   if (m_lcnt >= LS) m_nst = M_RUN;
                M_RUN:    if (m_bad || r_q[0]) m_nst = M_FREEZE;
                M_FREEZE: if (!m_bad) m_nst = r_q[0] ? M_SWITCH : M_RSTP;
                M_SWITCH: begin m_nst = M_RSTP; m_sel = !m_sel; end
                M_RSTP:   if (m_rcnt == RC - 1) m_nst = M_WAIT;
                M_WAIT:   if (m_lcnt >= LS) m_nst = M_RUN;
                          else if (m_tcnt == TO - 1) m_nst = M_FAULT;
                M_FAULT:  if (fclr) m_nst = M_IDLE;
                default:  m_nst = M_IDLE;
            endcase
            m_rcnt = (m_st == M_RSTP) ? m_rcnt + 1 : 0;
            m_tcnt = (m_st == M_WAIT) ? m_tcnt + 1 : 0;
            if (m_st == M_FREEZE || m_st == M_SWITCH || m_st == M_RSTP ||
                m_st == M_FAULT || !l_q[0])
                m_lcnt = 0;
            else if (m_lcnt < LS)
                m_lcnt = m_lcnt + 1;
            m_st = m_nst;
            void'(a_q.pop_front()); a_q.push_back(bad_a);
            void'(b_q.pop_front()); b_q.push_back(bad_b);
            void'(l_q.pop_front()); l_q.push_back(locked);
            void'(r_q.pop_front()); r_q.push_back(req);
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit e_pfd;
            e_pfd = !(a_q[0] | b_q[0]) &&
                    !(m_st == M_FREEZE || m_st == M_SWITCH || m_st == M_RSTP);
            chk("R2 pfd_en", int'(pfd_en), int'(e_pfd));
            chk("R3 clk_en", int'(clk_en), (m_st == M_RUN) ? (1 << NO) - 1 : 0);
            chk("R4 strobe", int'(strobe), int'(m_st == M_SWITCH));
            chk("R7 pll_rst", int'(pll_rst), int'(m_st == M_RSTP));
            chk("R6 sel", int'(sel), int'(m_sel));
            chk("R9 fault", int'(fault), int'(m_st == M_FAULT));
        end
    end

    // pulse monitors
    int strobe_cnt = 0, strobe_len = 0, strobe_max = 0, rst_len = 0, rst_last = 0;
    always @(negedge clk) begin
        if (strobe) begin
            strobe_len++;
            if (strobe_len == 1) strobe_cnt++;
            if (strobe_len > strobe_max) strobe_max = strobe_len;
        end else strobe_len = 0;
        if (pll_rst) rst_len++;
        else begin
            if (rst_len != 0) rst_last = rst_len;
            rst_len = 0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int sc, sv;
        cyc(3);
        chk("R1 pfd_en in reset", int'(pfd_en), 1);
        chk("R1 clk_en in reset", int'(clk_en), 0);
        chk("R1 rst/strobe/sel/fault in reset",
            int'({pll_rst, strobe, sel, fault}), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(1);
        chk("R1 outputs after reset", int'({pll_rst, strobe, sel, fault, clk_en}), 0);

        // R8: lock drops before the count completes, count restarts
        locked = 1'b1; cyc(10);
        locked = 1'b0; cyc(3);
        locked = 1'b1; cyc(12);
        chk("R8 no release after interrupted lock", int'(clk_en), 0);
        cyc(20);
        chk("R8 release after stable lock", int'(clk_en), (1 << NO) - 1);

        // R11: two-edge latency of a bad flag to pfd_en
        bad_a = 1'b1; cyc(1);
        chk("R11 pfd_en after one edge", int'(pfd_en), 1);
        cyc(1);
        chk("R11 pfd_en after two edges", int'(pfd_en), 0);
        cyc(1);
        chk("R3 outputs gated in freeze", int'(clk_en), 0);

        // R4: request held off while a reference is bad
        sc = strobe_cnt; sv = int'(sel);
        req = 1'b1; cyc(12);
        chk("R4 no strobe while bad", strobe_cnt, sc);
        bad_a = 1'b0;
        cyc(6);
        req = 1'b0;
        chk("R4 strobe once flags clear", strobe_cnt, sc + 1);
        chk("R5 strobe width", strobe_max, 1);
        chk("R6 selection flipped", int'(sel), 1 - sv);
        cyc(6);
        chk("R7 reset pulse cycles", rst_last, RC);
        cyc(30);
        chk("R8 outputs back after relock", int'(clk_en), (1 << NO) - 1);

        // R4: bad-only freeze re-locks without a strobe
        sc = strobe_cnt; sv = int'(sel); rst_last = 0;
        bad_b = 1'b1; cyc(5);
        bad_b = 1'b0; cyc(40);
        chk("R4 no strobe on bad-only freeze", strobe_cnt, sc);
        chk("R6 selection kept", int'(sel), sv);
        chk("R7 reset pulse on relock", rst_last, RC);
        chk("R3 running again", int'(clk_en), (1 << NO) - 1);

        // R9/R10: lock timeout and sticky fault
        locked = 1'b0; req = 1'b1; cyc(6);
        req = 1'b0;
        cyc(TO + 10);
        chk("R9 fault after timeout", int'(fault), 1);
        chk("R3 gated in fault", int'(clk_en), 0);
        locked = 1'b1; cyc(30);
        chk("R10 fault holds with lock back", int'(fault), 1);
        fclr = 1'b1; cyc(1);
        fclr = 1'b0; cyc(1);
        chk("R10 fault cleared", int'(fault), 0);
        cyc(25);
        chk("R10 running after clear", int'(clk_en), (1 << NO) - 1);

        cyc(2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule